// File: doc/BRIEF.md
# Decimal-Word Accumulator Core

This block is a small accumulator processor whose data words are signed decimal values bounded by plus and minus 9999. It runs a fetch and execute loop against an external synchronous memory of 100 word cells that answers a read one cycle after the request. Each instruction word is split arithmetically: dividing by 100 gives a two-digit operation code, and the remainder by 100 gives a two-digit operand address. The core holds a program counter, an accumulator, an instruction register and an operand register.

Every instruction takes five states. These are fetch, instruction capture, operand read, operand capture and execute. The cell named by the address digits is always read, whatever the operation is. The program counter advances by one when the operand read is issued, so it moves before execute and a branch loads its target unchanged. Words enter and leave through valid/ready ports. The machine stops for good on a halt instruction or on a fault. A fault reports a code and the address that caused it, which is enough for a later dump of memory. Program loading is done by the memory's owner while the core is held in reset.

Top module: `dec_acc_core`

## Requirements
- R1: While reset is held, the accumulator reads 0, `halted` is 0, `fault_code` is 0, and the core requests a read of cell START_PC (default 0).
- R2: An instruction word w >= 0 splits into operation code w/100 and address w%100. The cell at that address is read before execute for every operation, including halt and branches.
- R3: The program counter advances by one before execute. A taken branch sets it to exactly the address digits. A fault raised during execute reports the instruction's own address.
- R4: READ (code 10) waits with `in_ready` low until `in_valid` is high. It then raises `in_ready` for the accepting cycle and writes `in_word` to the addressed cell.
- R5: WRITE (code 11) drives the addressed cell's word on `out_word` with `out_valid` high. It holds both unchanged until a cycle with `out_ready` high.
- R6: LOAD (code 20) copies the addressed cell into the accumulator. STORE (code 21) writes the accumulator into the addressed cell.
- R7: ADD (30), SUBTRACT (31) and MULTIPLY (33) replace the accumulator with acc+cell, acc-cell and acc*cell.
- R8: DIVIDE (32) and MODULUS (34) give acc/cell truncated toward zero, and the remainder carrying the sign of the accumulator.
- R9: BRANCH (40) is always taken. BRANCHNEG (41) is taken only when acc < 0. BRANCHZERO (42) is taken only when acc == 0.
- R10: HALT (43) sets `halted` with `fault_code` 0. Once `halted` is set, it stays set, the fault outputs stay unchanged, and no memory, input or output traffic occurs until reset.
- R11: An arithmetic result, or a READ input word, outside -9999..9999 stops the core with `fault_code` 2. The accumulator and memory are left unchanged.
- R12: DIVIDE or MODULUS by a zero cell stops the core with `fault_code` 3.
- R13: A fetch with the program counter at or beyond 100 stops the core with `fault_code` 1. `fault_addr` then holds that counter value, and no read is issued.
- R14: An undefined operation code, or a negative instruction word, stops the core with `fault_code` 4 and the instruction's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_en | output | 1 | Memory access request this cycle |
| mem_we | output | 1 | Access is a write when high, a read when low |
| mem_addr | output | 7 | Cell address |
| mem_wdata | output | 15 | Signed word to write |
| mem_rdata | input | 15 | Signed word read, valid the cycle after a read request |
| in_valid | input | 1 | Input word offered |
| in_word | input | 15 | Signed input word |
| in_ready | output | 1 | Input word taken this cycle |
| out_valid | output | 1 | Output word offered |
| out_word | output | 15 | Signed output word |
| out_ready | input | 1 | Output word taken this cycle |
| acc_word | output | 15 | Accumulator contents |
| halted | output | 1 | Core stopped by halt or fault |
| fault_code | output | 3 | 0 none, 1 address, 2 overflow, 3 divide by zero, 4 illegal |
| fault_addr | output | 7 | Offending program counter or instruction address |

## Verification
The bound checker watches, on every cycle, the invariants that hold no matter which program runs. It checks that the halted state is sticky and silent, that the accumulator and every written word stay inside the decimal range, that memory addresses stay below 100, that a pending output is held steady, and that input is only accepted when offered. What the scenarios alone can show is the meaning of each instruction. That covers the arithmetic results and their truncation, which branches are taken, the exact branch target and fault address, and the operand read that happens even for halt. The scenarios check these by running short programs and comparing output words, final memory cells and the fault reports against values worked out by hand.

// File: rtl/dac_pkg.sv
package dac_pkg;
  localparam int OP_W = 7;

  localparam logic [OP_W-1:0] OP_READ  = 7'd10;
  localparam logic [OP_W-1:0] OP_WRITE = 7'd11;
  localparam logic [OP_W-1:0] OP_LOAD  = 7'd20;
  localparam logic [OP_W-1:0] OP_STORE = 7'd21;
  localparam logic [OP_W-1:0] OP_ADD   = 7'd30;
  localparam logic [OP_W-1:0] OP_SUB   = 7'd31;
  localparam logic [OP_W-1:0] OP_DIV   = 7'd32;
  localparam logic [OP_W-1:0] OP_MUL   = 7'd33;
  localparam logic [OP_W-1:0] OP_MOD   = 7'd34;
  localparam logic [OP_W-1:0] OP_JMP   = 7'd40;
  localparam logic [OP_W-1:0] OP_JNEG  = 7'd41;
  localparam logic [OP_W-1:0] OP_JZERO = 7'd42;
  localparam logic [OP_W-1:0] OP_HALT  = 7'd43;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_ADDR = 3'd1,
    FLT_OVF  = 3'd2,
    FLT_DIVZ = 3'd3,
    FLT_ILL  = 3'd4
  } fault_e;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_IRCAP,
    ST_OPRD,
    ST_OPCAP,
    ST_EXEC,
    ST_STOP
  } state_e;
endpackage

// File: rtl/dac_rst_sync.sv
module dac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = chain_q[STAGES-1];
endmodule

// File: rtl/dac_split.sv
module dac_split #(
  parameter int W    = 15,
  parameter int BASE = 100,
  localparam int SW  = $clog2(BASE)
) (
  input  logic signed [W-1:0]       word,
  output logic [dac_pkg::OP_W-1:0]  op,
  output logic [SW-1:0]             addr,
  output logic                      neg
);
  logic [W-1:0] mag;

  always_comb begin
    neg  = word[W-1];
    mag  = neg ? W'(-word) : W'(word);
    op   = dac_pkg::OP_W'(mag / W'(BASE));
    addr = SW'(mag % W'(BASE));
  end
endmodule

// File: rtl/dac_alu.sv
module dac_alu #(
  parameter int W    = 15,
  parameter int WMAX = 9999
) (
  input  logic [dac_pkg::OP_W-1:0] op,
  input  logic signed [W-1:0]      a,
  input  logic signed [W-1:0]      b,
  output logic signed [W-1:0]      res,
  output logic                     ovf,
  output logic                     divz
);
  import dac_pkg::*;

  localparam int WW = 2 * W;
  localparam logic signed [WW-1:0] LIM = WW'(WMAX);

  logic signed [WW-1:0] wa, wb, wb_safe, wide;

  always_comb begin
    wa      = WW'(a);
    wb      = WW'(b);
    divz    = 1'b0;
    wb_safe = (b == '0) ? WW'(1) : wb;
    case (op)
      OP_ADD: wide = wa + wb;
      OP_SUB: wide = wa - wb;
      OP_MUL: wide = wa * wb;
      OP_DIV: begin
        wide = wa / wb_safe;
        divz = (b == '0);
      end
      OP_MOD: begin
        wide = wa % wb_safe;
        divz = (b == '0);
      end
      default: wide = wa;
    endcase
    ovf = (wide > LIM) || (wide < -LIM);
    res = W'(wide);
  end
endmodule

// File: rtl/dac_ctrl.sv
module dac_ctrl #(
  parameter int W        = 15,
  parameter int WMAX     = 9999,
  parameter int DEPTH    = 100,
  parameter int BASE     = 100,
  parameter int START_PC = 0,
  localparam int AW      = $clog2(DEPTH + 1),
  localparam int SW      = $clog2(BASE)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  output logic                      mem_en,
  output logic                      mem_we,
  output logic [AW-1:0]             mem_addr,
  output logic signed [W-1:0]       mem_wdata,
  input  logic signed [W-1:0]       mem_rdata,
  input  logic                      in_valid,
  input  logic signed [W-1:0]       in_word,
  output logic                      in_ready,
  output logic                      out_valid,
  output logic signed [W-1:0]       out_word,
  input  logic                      out_ready,
  output logic signed [W-1:0]       ir_q,
  output logic signed [W-1:0]       acc_q,
  output logic signed [W-1:0]       opnd_q,
  input  logic [dac_pkg::OP_W-1:0]  op,
  input  logic [SW-1:0]             op_addr,
  input  logic                      op_neg,
  input  logic signed [W-1:0]       alu_res,
  input  logic                      alu_ovf,
  input  logic                      alu_divz,
  output logic                      halted,
  output logic [2:0]                fault_code,
  output logic [AW-1:0]             fault_addr
);
  import dac_pkg::*;

  localparam logic signed [W-1:0] LIM_P = W'(WMAX);
  localparam logic signed [W-1:0] LIM_N = -LIM_P;

  state_e               st_q, st_n;
  logic [AW-1:0]        pc_q, pc_n;
  logic signed [W-1:0]  acc_n, ir_n, opnd_n;
  fault_e               fc_q, fc_n;
  logic [AW-1:0]        fa_q, fa_n;
  logic                 addr_ok, in_oor;
  logic [AW-1:0]        ins_addr;

  assign addr_ok  = (int'(op_addr) < DEPTH);
  assign in_oor   = (in_word > LIM_P) || (in_word < LIM_N);
  assign ins_addr = pc_q - AW'(1);

  always_comb begin
    st_n      = st_q;
    pc_n      = pc_q;
    acc_n     = acc_q;
    ir_n      = ir_q;
    opnd_n    = opnd_q;
    fc_n      = fc_q;
    fa_n      = fa_q;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = pc_q;
    mem_wdata = acc_q;
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_word  = opnd_q;
    case (st_q)
      ST_FETCH: begin
        if (int'(pc_q) >= DEPTH) begin
          fc_n = FLT_ADDR;
          fa_n = pc_q;
          st_n = ST_STOP;
        end else begin
          mem_en   = 1'b1;
          mem_addr = pc_q;
          st_n     = ST_IRCAP;
        end
      end
      ST_IRCAP: begin
        ir_n = mem_rdata;
        st_n = ST_OPRD;
      end
      ST_OPRD: begin
        if (op_neg) begin
          fc_n = FLT_ILL;
          fa_n = pc_q;
          st_n = ST_STOP;
        end else if (!addr_ok) begin
          fc_n = FLT_ADDR;
          fa_n = AW'(op_addr);
          st_n = ST_STOP;
        end else begin
          mem_en   = 1'b1;
          mem_addr = AW'(op_addr);
          pc_n     = pc_q + AW'(1);
          st_n     = ST_OPCAP;
        end
      end
      ST_OPCAP: begin
        opnd_n = mem_rdata;
        st_n   = ST_EXEC;
      end
      ST_EXEC: begin
        case (op)
          OP_READ: begin
            if (in_valid) begin
              if (in_oor) begin
                fc_n = FLT_OVF;
                fa_n = ins_addr;
                st_n = ST_STOP;
              end else begin
                in_ready  = 1'b1;
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = AW'(op_addr);
                mem_wdata = in_word;
                st_n      = ST_FETCH;
              end
            end
          end
          OP_WRITE: begin
            out_valid = 1'b1;
            if (out_ready) st_n = ST_FETCH;
          end
          OP_LOAD: begin
            acc_n = opnd_q;
            st_n  = ST_FETCH;
          end
          OP_STORE: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = AW'(op_addr);
            mem_wdata = acc_q;
            st_n      = ST_FETCH;
          end
          OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_MOD: begin
            if (alu_divz) begin
              fc_n = FLT_DIVZ;
              fa_n = ins_addr;
              st_n = ST_STOP;
            end else if (alu_ovf) begin
              fc_n = FLT_OVF;
              fa_n = ins_addr;
              st_n = ST_STOP;
            end else begin
              acc_n = alu_res;
              st_n  = ST_FETCH;
            end
          end
          OP_JMP: begin
            pc_n = AW'(op_addr);
            st_n = ST_FETCH;
          end
          OP_JNEG: begin
            if (acc_q < 0) pc_n = AW'(op_addr);
            st_n = ST_FETCH;
          end
          OP_JZERO: begin
            if (acc_q == '0) pc_n = AW'(op_addr);
            st_n = ST_FETCH;
          end
          OP_HALT: st_n = ST_STOP;
          default: begin
            fc_n = FLT_ILL;
            fa_n = ins_addr;
            st_n = ST_STOP;
          end
        endcase
      end
      default: st_n = ST_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_FETCH;
      pc_q   <= AW'(START_PC);
      acc_q  <= '0;
      ir_q   <= '0;
      opnd_q <= '0;
      fc_q   <= FLT_NONE;
      fa_q   <= '0;
    end else begin
      st_q <= st_n;
      pc_q <= pc_n;
      if (st_q == ST_EXEC)  acc_q  <= acc_n;
      if (st_q == ST_IRCAP) ir_q   <= ir_n;
      if (st_q == ST_OPCAP) opnd_q <= opnd_n;
      if (st_q != ST_STOP) begin
        fc_q <= fc_n;
        fa_q <= fa_n;
      end
    end
  end

  assign halted     = (st_q == ST_STOP);
  assign fault_code = fc_q;
  assign fault_addr = fa_q;
endmodule

// File: rtl/dec_acc_core.sv
module dec_acc_core #(
  parameter int W        = 15,
  parameter int WMAX     = 9999,
  parameter int DEPTH    = 100,
  parameter int BASE     = 100,
  parameter int START_PC = 0,
  localparam int AW      = $clog2(DEPTH + 1),
  localparam int SW      = $clog2(BASE)
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic                mem_en,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic signed [W-1:0] mem_wdata,
  input  logic signed [W-1:0] mem_rdata,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_word,
  output logic                in_ready,
  output logic                out_valid,
  output logic signed [W-1:0] out_word,
  input  logic                out_ready,
  output logic signed [W-1:0] acc_word,
  output logic                halted,
  output logic [2:0]          fault_code,
  output logic [AW-1:0]       fault_addr
);
  logic                      rst_s_n;
  logic signed [W-1:0]       ir_q, opnd_q, alu_res;
  logic [dac_pkg::OP_W-1:0]  op;
  logic [SW-1:0]             op_addr;
  logic                      op_neg, alu_ovf, alu_divz;

  dac_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  dac_split #(.W(W), .BASE(BASE)) u_split (
    .word(ir_q), .op(op), .addr(op_addr), .neg(op_neg)
  );

  dac_alu #(.W(W), .WMAX(WMAX)) u_alu (
    .op(op), .a(acc_word), .b(opnd_q),
    .res(alu_res), .ovf(alu_ovf), .divz(alu_divz)
  );

  dac_ctrl #(
    .W(W), .WMAX(WMAX), .DEPTH(DEPTH), .BASE(BASE), .START_PC(START_PC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_s_n),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
    .out_valid(out_valid), .out_word(out_word), .out_ready(out_ready),
    .ir_q(ir_q), .acc_q(acc_word), .opnd_q(opnd_q),
    .op(op), .op_addr(op_addr), .op_neg(op_neg),
    .alu_res(alu_res), .alu_ovf(alu_ovf), .alu_divz(alu_divz),
    .halted(halted), .fault_code(fault_code), .fault_addr(fault_addr)
  );
endmodule

// File: rtl/dac_chk.sv
module dac_chk #(
  parameter int W     = 15,
  parameter int WMAX  = 9999,
  parameter int DEPTH = 100,
  localparam int AW   = $clog2(DEPTH + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                mem_en,
  input logic                mem_we,
  input logic [AW-1:0]       mem_addr,
  input logic signed [W-1:0] mem_wdata,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic signed [W-1:0] out_word,
  input logic                out_ready,
  input logic signed [W-1:0] acc_word,
  input logic                halted,
  input logic [2:0]          fault_code
);
  localparam logic signed [W-1:0] LIM_P = W'(WMAX);
  localparam logic signed [W-1:0] LIM_N = -LIM_P;

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R10
  AST_FAULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(fault_code)); // R10
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_en && !in_ready && !out_valid)); // R10
  AST_ACC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_word <= LIM_P) && (acc_word >= LIM_N)); // R11
  AST_WDATA_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> ((mem_wdata <= LIM_P) && (mem_wdata >= LIM_N))); // R11
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (int'(mem_addr) < DEPTH)); // R13
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word))); // R5
  AST_IN_OFFERED: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> in_valid); // R4
endmodule

bind dec_acc_core dac_chk #(.W(W), .WMAX(WMAX), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_word(out_word),
  .out_ready(out_ready), .acc_word(acc_word), .halted(halted),
  .fault_code(fault_code)
);

// File: tb/sim_dec_acc_core.sv
module sim_dec_acc_core;
  logic               clk, rst_n;
  logic               mem_en, mem_we;
  logic [6:0]         mem_addr;
  logic signed [14:0] mem_wdata, mem_rdata;
  logic               in_valid, in_ready;
  logic signed [14:0] in_word;
  logic               out_valid, out_ready;
  logic signed [14:0] out_word, acc_word;
  logic               halted;
  logic [2:0]         fault_code;
  logic [6:0]         fault_addr;

  logic               ld_en, ld_clr, rd99;
  logic [6:0]         ld_a;
  logic signed [14:0] ld_d;
  logic signed [14:0] bmem [0:99];

  int n_chk = 0;
  int n_bad = 0;
  int in_q[$];
  int exp_q[$];
  int cyc = 0;
  int gap = 0;
  bit in_pend = 0;

  dec_acc_core u0 (
    .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
    .out_valid(out_valid), .out_word(out_word), .out_ready(out_ready),
    .acc_word(acc_word), .halted(halted), .fault_code(fault_code),
    .fault_addr(fault_addr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (ld_clr) begin
      for (int i = 0; i < 100; i++) bmem[i] <= '0;
      rd99 <= 1'b0;
    end else if (ld_en) begin
      bmem[ld_a] <= ld_d;
    end else if (mem_en) begin
      if (mem_we) bmem[mem_addr] <= mem_wdata;
      else begin
        mem_rdata <= bmem[mem_addr];
        if (mem_addr == 7'd99) rd99 <= 1'b1;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor for output words; out_ready follows a stall pattern
  always @(negedge clk) begin
    cyc++;
    out_ready = (cyc % 3 == 2);
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) chk("R5 unexpected output", int'(out_word), -99999);
      else chk("R5 output word", int'(out_word), exp_q.pop_front());
    end
  end

  // input driver: offers each queued word after a short gap
  always @(negedge clk) begin
    if (in_pend) begin
      void'(in_q.pop_front());
      gap = 0;
    end
    in_pend = 0;
    if (in_q.size() > 0 && gap >= 3) begin
      in_valid = 1'b1;
      in_word  = 15'(in_q[0]);
    end else begin
      in_valid = 1'b0;
    end
    gap++;
    #1;
    if (in_ready && !in_valid) chk("R4 ready without valid", 1, 0);
    in_pend = in_valid && in_ready;
  end

  function automatic int enc(int op, int a);
    return op * 100 + a;
  endfunction

  task automatic poke(int a, int v);
    @(negedge clk);
    ld_en = 1'b1; ld_a = 7'(a); ld_d = 15'(v);
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic begin_test;
    @(negedge clk);
    rst_n = 1'b0;
    in_q.delete();
    exp_q.delete();
    @(negedge clk);
    ld_clr = 1'b1;
    @(negedge clk);
    ld_clr = 1'b0;
  endtask

  task automatic run(string tag);
    int k;
    @(negedge clk);
    rst_n = 1'b1;
    k = 0;
    while (!halted && k < 4000) begin
      @(negedge clk);
      k++;
    end
    chk({tag, " halted"}, int'(halted), 1);
    repeat (3) @(negedge clk);
    chk("R10 no memory traffic after stop", int'(mem_en), 0);
    chk({tag, " pending outputs"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ld_en = 1'b0; ld_clr = 1'b0; ld_a = '0; ld_d = '0;
    in_valid = 1'b0; in_word = '0; out_ready = 1'b0;

    // R1 reset state
    begin_test();
    @(negedge clk);
    chk("R1 acc at reset", int'(acc_word), 0);
    chk("R1 halted at reset", int'(halted), 0);
    chk("R1 fault code at reset", int'(fault_code), 0);
    chk("R1 first fetch address", int'(mem_addr), 0);
    chk("R1 fetch request", int'(mem_en), 1);

    // R2 R4 R5 R6 R7 R10: I/O, load/store, add/sub/mul, halt
    begin_test();
    poke(0, enc(10, 50)); poke(1, enc(10, 51));
    poke(2, enc(20, 50)); poke(3, enc(30, 51)); poke(4, enc(21, 52));
    poke(5, enc(11, 52)); poke(6, enc(20, 50)); poke(7, enc(31, 51));
    poke(8, enc(21, 53)); poke(9, enc(33, 51)); poke(10, enc(21, 54));
    poke(11, enc(11, 54)); poke(12, enc(43, 99)); poke(98, 4321);
    in_q.push_back(37); in_q.push_back(-12);
    exp_q.push_back(25); exp_q.push_back(-588);
    run("R10");
    chk("R4 input stored", int'(bmem[50]), 37);
    chk("R4 negative input stored", int'(bmem[51]), -12);
    chk("R7 add result", int'(bmem[52]), 25);
    chk("R7 subtract result", int'(bmem[53]), 49);
    chk("R7 multiply result", int'(bmem[54]), -588);
    chk("R6 accumulator after run", int'(acc_word), -588);
    chk("R10 halt gives no fault", int'(fault_code), 0);
    chk("R2 halt operand cell read", int'(rd99), 1);
    chk("R6 untouched cell", int'(bmem[98]), 4321);

    // R3 R8 R9: divide, remainder, branches
    begin_test();
    poke(0, enc(20, 20)); poke(1, enc(32, 21)); poke(2, enc(21, 30));
    poke(3, enc(20, 20)); poke(4, enc(34, 21)); poke(5, enc(21, 31));
    poke(6, enc(41, 9));  poke(7, enc(21, 32)); poke(8, enc(43, 0));
    poke(9, enc(20, 22)); poke(10, enc(42, 13)); poke(11, enc(21, 32));
    poke(12, enc(43, 0)); poke(13, enc(20, 23)); poke(14, enc(41, 7));
    poke(15, enc(42, 7)); poke(16, enc(40, 18)); poke(17, enc(43, 0));
    poke(18, enc(21, 33)); poke(19, enc(43, 0));
    poke(20, -17); poke(21, 5); poke(22, 0); poke(23, 5); poke(32, 777);
    run("R9");
    chk("R8 divide truncates toward zero", int'(bmem[30]), -3);
    chk("R8 remainder sign of dividend", int'(bmem[31]), -2);
    chk("R9 skipped stores", int'(bmem[32]), 777);
    chk("R3 branch target exact", int'(bmem[33]), 5);
    chk("R9 final acc", int'(acc_word), 5);
    chk("R9 no fault", int'(fault_code), 0);

    // R11 arithmetic overflow
    begin_test();
    poke(0, enc(20, 10)); poke(1, enc(30, 11)); poke(10, 9000); poke(11, 1000);
    run("R11");
    chk("R11 overflow code", int'(fault_code), 2);
    chk("R11 fault address", int'(fault_addr), 1);
    chk("R11 acc unchanged", int'(acc_word), 9000);

    // R11 input out of range
    begin_test();
    poke(0, enc(10, 10)); poke(10, 55);
    in_q.push_back(12000);
    run("R11");
    chk("R11 input overflow code", int'(fault_code), 2);
    chk("R11 input fault address", int'(fault_addr), 0);
    chk("R11 cell not written", int'(bmem[10]), 55);

    // R12 divide by zero
    begin_test();
    poke(0, enc(20, 10)); poke(1, enc(32, 11)); poke(10, 40);
    run("R12");
    chk("R12 divide by zero code", int'(fault_code), 3);
    chk("R12 fault address", int'(fault_addr), 1);

    // R13 program counter runs off the end
    begin_test();
    poke(0, enc(40, 98)); poke(98, enc(20, 10)); poke(99, enc(20, 10));
    poke(10, 3);
    run("R13");
    chk("R13 address fault code", int'(fault_code), 1);
    chk("R13 fault address is pc", int'(fault_addr), 100);
    chk("R3 acc from last load", int'(acc_word), 3);

    // R14 undefined opcode
    begin_test();
    poke(0, enc(20, 10)); poke(1, enc(50, 0)); poke(10, 8);
    run("R14");
    chk("R14 illegal code", int'(fault_code), 4);
    chk("R14 fault address", int'(fault_addr), 1);

    // R14 negative instruction word
    begin_test();
    poke(0, -1020);
    run("R14");
    chk("R14 negative word code", int'(fault_code), 4);
    chk("R14 negative word address", int'(fault_addr), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule